// File: doc/BRIEF.md
# Guarded Service Request Register

This block holds one bank of per-channel service requests for a timer engine. Each of the eight channels owns a 2-bit field in a 16-bit host-writable register. Software posts a request for a channel by writing a nonzero code into that channel's field. The channel's own hardware returns the field to the idle value when it has finished the service. Two instances cover sixteen channels.

The host never needs a read-modify-write. A guard in front of every field discards any written 00, so software can target one channel with a single store. That store carries the wanted code in the channel's field and 00 in every other field. The other channels' fields keep whatever they held, including any value that channel hardware changed between the host's read and write.

Top module: `svc_req_bank`

## Requirements
- R1: Channel k occupies bits [2k+1:2k] of both the write data and the read data, so channel 7 is in bits [15:14] and channel 0 is in bits [1:0].
- R2: When `wr_en` is high and a field of `wr_data` is 01, 10 or 11, that channel's field takes the written code at the next clock edge.
- R3: When `wr_en` is high and a field of `wr_data` is 00, that channel's field keeps its current value.
- R4: A write that carries a nonzero code for one channel and 00 for all others changes only that channel's field.
- R5: A high `done_stb[k]` with no accepted write to channel k sets field k to 00 at the next edge, and leaves every other field unchanged.
- R6: When `done_stb[k]` and an accepted nonzero write to channel k occur in the same cycle, field k takes the written code.
- R7: `pending[k]` is high exactly when field k is not 00.
- R8: While `rst_n` is low at a clock edge, all fields become 00. The reset is synchronous and active low.
- R9: With `wr_en` low, `wr_data` has no effect on any field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe for this bank |
| wr_data | input | 16 | Host write data, eight 2-bit codes |
| rd_data | output | 16 | Current contents of all fields |
| done_stb | input | 8 | Per-channel service-complete strobes |
| pending | output | 8 | Per-channel request-outstanding flags |

## Verification
A field that is wrong inside the block shows on `rd_data` and `pending` at the first edge after the stimulus that caused it, because both outputs come straight from the field registers. If the guard let a 00 through, a neighbouring channel's nonzero code would read back as 00 and its pending flag would drop in that cycle. If the priority between a write and a completion were reversed, the targeted field would read 00 after a write that collides with a completion strobe. The bench keeps an independent model of the eight fields and compares both output ports on every clock. Any error is reported one cycle after it occurs.

// File: rtl/svc_req_pkg.sv
// Package: shared code values and widths for the service request bank.
// Assumes: codes are 2 bits; 00 is the idle (service complete) value.
package svc_req_pkg;
    localparam int CODE_W = 2;
    typedef enum logic [CODE_W-1:0] {
        SVC_IDLE  = 2'b00,
        SVC_INIT  = 2'b01,
        SVC_REQ_A = 2'b10,
        SVC_REQ_B = 2'b11
    } svc_code_t;
endpackage

// File: rtl/svc_write_guard.sv
// Module: splits the host write word into per-channel codes and marks the
// fields whose code is a request code (nonzero) as accepted.
// Assumes: channel k sits at bits [CODE_W*k +: CODE_W].
module svc_write_guard #(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 2,
    localparam int WORD_W = NUM_CH * CODE_W
) (
    input  logic                           wr_en,
    input  logic [WORD_W-1:0]              wr_data,
    output logic [NUM_CH-1:0]              accept,
    output logic [NUM_CH-1:0][CODE_W-1:0]  code
);
    for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
        // Slice one channel's code and gate it on nonzero value.
        always_comb begin
            code[k]   = wr_data[CODE_W*k +: CODE_W];
            accept[k] = wr_en && (wr_data[CODE_W*k +: CODE_W] != '0);
        end
    end
endmodule

// File: rtl/svc_field_cell.sv
// Module: one channel's request field. A guarded host write wins over the
// channel's completion strobe; the strobe alone returns the field to idle.
// Assumes: wr_accept is already qualified as a nonzero code.
module svc_field_cell #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_accept,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              done_stb,
    output logic [CODE_W-1:0] field_q,
    output logic              pending
);
    // Field register: reset, host write, then completion, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            field_q <= '0;
        else if (wr_accept)
            field_q <= wr_code;
        else if (done_stb)
            field_q <= '0;
    end

    // Pending flag: any non-idle code is an outstanding request.
    always_comb pending = (field_q != '0);

    // R6
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> field_q == $past(wr_code));
    // R5
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_stb && !wr_accept) |=> field_q == '0);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_accept && !done_stb) |=> $stable(field_q));
endmodule

// File: rtl/svc_req_bank.sv
// Module: top of one bank of eight guarded service request fields.
// Assumes: bus decoding produces wr_en for this bank; completion strobes
// come from the channel service logic, one cycle wide or longer.
module svc_req_bank
    import svc_req_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int WORD_W = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic [NUM_CH-1:0] done_stb,
    output logic [NUM_CH-1:0] pending
);
    logic [NUM_CH-1:0]             accept;
    logic [NUM_CH-1:0][CODE_W-1:0] code;

    svc_write_guard #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_guard (
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .accept (accept),
        .code   (code)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic [CODE_W-1:0] fq;
        svc_field_cell #(.CODE_W(CODE_W)) i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_accept(accept[k]),
            .wr_code  (code[k]),
            .done_stb (done_stb[k]),
            .field_q  (fq),
            .pending  (pending[k])
        );
        // Place channel k's field at its fixed position in the read word.
        always_comb rd_data[CODE_W*k +: CODE_W] = fq;

        // R7
        pending_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pending[k] == (rd_data[CODE_W*k +: CODE_W] != '0));
    end
endmodule

// File: tb/test_svc_req_bank.sv
module test_svc_req_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [7:0]  done_stb = '0;
    logic [7:0]  pending;

    int model [NCH];
    int n_checks = 0;
    int n_fail = 0;

    svc_req_bank i_svc_req_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .done_stb(done_stb), .pending(pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] exp_word();
        logic [15:0] w = '0;
        for (int k = 0; k < NCH; k++) w = w | (16'(model[k]) << (2*k));
        return w;
    endfunction

    function automatic logic [7:0] exp_pend();
        logic [7:0] p = '0;
        for (int k = 0; k < NCH; k++) p[k] = (model[k] != 0);
        return p;
    endfunction

    task automatic compare(input string tag);
        n_checks++;
        if (rd_data !== exp_word()) begin
            n_fail++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, exp_word());
        end
        n_checks++;
        if (pending !== exp_pend()) begin
            n_fail++;
            $display("FAIL %s R7 pending actual=%b expected=%b", tag, pending, exp_pend());
        end
    endtask

    // Drive one cycle at the falling edge, advance model, compare after edge.
    task automatic step(input logic rn, input logic we, input logic [15:0] d,
                        input logic [7:0] dn, input string tag);
        @(negedge clk);
        rst_n = rn; wr_en = we; wr_data = d; done_stb = dn;
        @(posedge clk);
        #1;
        for (int k = 0; k < NCH; k++) begin
            int c = int'((d >> (2*k)) & 16'h3);
            if (!rn)                model[k] = 0;
            else if (we && c != 0)  model[k] = c;
            else if (dn[k])         model[k] = 0;
        end
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < NCH; k++) model[k] = 0;
        step(0, 0, 16'h0, 8'h00, "R8 reset");
        step(0, 1, 16'hFFFF, 8'h00, "R8 reset holds over write");
        // R2 R1: one field per channel position, every code
        step(1, 1, 16'h0001, 8'h00, "R2 R1 ch0 init");
        step(1, 1, 16'h8000, 8'h00, "R2 R1 ch7 code 10");
        step(1, 1, 16'h0C00, 8'h00, "R2 R1 ch5 code 11");
        // R4 R3: single-field writes leave others alone
        step(1, 1, 16'h0040, 8'h00, "R4 ch3 only");
        step(1, 1, 16'h0000, 8'h00, "R3 all-zero write");
        step(1, 1, 16'h0002, 8'h00, "R3 R4 overwrite ch0 keeps others");
        // R9 write disabled
        step(1, 0, 16'h5555, 8'h00, "R9 no wr_en");
        // R5 completion
        step(1, 0, 16'h0, 8'h80, "R5 ch7 done");
        step(1, 0, 16'h0, 8'h02, "R5 done on idle ch1");
        // R6 collision
        step(1, 1, 16'h0004, 8'h02, "R6 write beats done ch1");
        step(1, 1, 16'h0010, 8'h09, "R6 R5 ch2 write, ch0 ch3 done");
        step(1, 1, 16'hAAAA, 8'hFF, "R6 all write all done");
        step(1, 0, 16'h0, 8'h55, "R5 even channels done");
        step(1, 1, 16'h3300, 8'hF0, "R3 R5 mixed zero fields and done");
        // mixed sweep
        for (int i = 0; i < 40; i++)
            step(1, i[0], 16'((i * 16'h3B7) ^ 16'h9C21), 8'((i * 37) ^ 8'h5A), "R2 R3 R5 sweep");
        step(0, 1, 16'h1234, 8'h00, "R8 mid-run reset");
        step(1, 0, 16'h0, 8'hFF, "R8 after reset idle");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule